// File: doc/BRIEF.md
# Single-Word MDIO Management Master

This block drives the two-wire management bus (MDC clock, bidirectional MDIO data) of Ethernet PHYs using the Clause 22 frame format. A host controls it through one 32-bit control word. The host writes a word that sets the go bit, the enable, the direction, a PHY address, a register address and, for writes, 16 data bits. The block then produces MDC from the system clock with a programmable divider. It sends one complete frame and clears the go bit when the frame has ended. On a read, the 16 bits returned by the PHY replace the data field of the stored word, so the host polls the same word for completion and for the result.

The control word is a plain register port and has no stream handshake. The host may write on any cycle. A write is taken only while the go bit reads 0, and a write arriving during a frame is dropped with no other effect. The MDIO pad is split into an output value, an output enable and an input. The pad, pull-up and tristate buffer live outside the block.

Control word layout: bit 31 go/busy, bit 30 enable, bit 27 read (1) or write (0), bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data. Bits 29:28 and 26 are stored and read back as written.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the control word reads 0, MDC is low and the MDIO output enable is low.
- R2: A write with bits 31 and 30 both set starts a frame. For a divider setting N, the control word then reads with bit 31 set for exactly 128*(N+1) clock cycles, counted from the cycle after the write, and holds the written word while busy. With N of 30 or less at 200 MHz, the transaction completes in under 20 us.
- R3: During a frame, MDC is high for N+1 cycles in each of its 64 periods, and the frame ends on a falling MDC edge. While bit 31 reads 0, MDC stays low.
- R4: A write frame, sampled on the rising edges of MDC and sent MSB first, is: 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, and data bits 15:0. The output enable stays high for all 64 bits.
- R5: MDIO changes only in the cycle in which MDC falls.
- R6: A read frame uses opcode 10. The output enable drops for the two turnaround bits and the 16 data bits. The 16 bits sampled on the rising MDC edges of the data phase, first bit into bit 15, replace bits 15:0 when bit 31 clears. All other fields keep their written values.
- R7: A write to the control word while bit 31 reads 1 is ignored. The stored word and the frame in progress are unchanged.
- R8: A write with bit 31 set and bit 30 clear starts no frame. The word is stored with bit 31 cleared, and MDC stays low.
- R9: A write with bit 31 clear is stored as written and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc_half | input | DIV_W | MDC half period minus one, in clock cycles (N) |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word to write |
| reg_rdata | output | 32 | Current control word, including busy and read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO line value from the pad |

## Verification
The go bit is due in the first cycle after the accepting edge. It must stay set for exactly 128*(N+1) samples, so the bench counts busy samples at every falling system clock edge and compares the count with that product for several N. A monitor finds each rising MDC edge by comparing MDC with its value at the previous falling clock edge. It records the line value and the output enable in a 64-bit vector and compares that vector with the expected frame queued by the driver. The returned data and the rejection of writes during a frame are read back through the control word in the cycle after completion, or in the cycle after the rejected write.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CTRL_W = 32;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  typedef struct packed {
    logic              go;
    logic              en;
    logic [1:0]        spare_hi;
    logic              rd;
    logic              spare_lo;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regn;
    logic [DATA_W-1:0] data;
  } mdio_ctrl_t;

  localparam logic [1:0] ST_CODE  = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TA_WRITE = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             edge_now;

  assign edge_now  = run && (cnt_q == half);
  assign rise_tick = edge_now && !mdc_q;
  assign fall_tick = edge_now && mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (cnt_q == half) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmd_rd,
  input  logic [ADDR_W-1:0] cmd_phy,
  input  logic [ADDR_W-1:0] cmd_reg,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int TA_FIRST   = PRE_BITS + 14;
  localparam int DATA_FIRST = PRE_BITS + 16;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] sh_q;
  logic [CNT_W-1:0]      bit_q;
  logic                  act_q;
  logic                  rd_q;
  logic [DATA_W-1:0]     cap_q;

  assign active  = act_q;
  assign done    = act_q && fall_tick && (bit_q == LAST_IDX);
  assign mdio_o  = act_q ? sh_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe = act_q && !(rd_q && (int'(bit_q) >= TA_FIRST));
  assign rd_data = cap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= '0;
      act_q <= 1'b0;
      rd_q  <= 1'b0;
    end else if (start) begin
      sh_q  <= {{PRE_BITS{1'b1}}, ST_CODE, (cmd_rd ? OP_READ : OP_WRITE),
                cmd_phy, cmd_reg, (cmd_rd ? 2'b11 : TA_WRITE),
                (cmd_rd ? {DATA_W{1'b1}} : cmd_data)};
      bit_q <= '0;
      act_q <= 1'b1;
      rd_q  <= cmd_rd;
    end else if (act_q && fall_tick) begin
      if (bit_q == LAST_IDX) begin
        act_q <= 1'b0;
      end else begin
        bit_q <= bit_q + 1'b1;
        sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (act_q && rise_tick && rd_q && (int'(bit_q) >= DATA_FIRST)) begin
      cap_q <= {cap_q[DATA_W-2:0], mdio_i};
    end
  end

  // R5
  mdio_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q) && (mdio_o != $past(mdio_o))) |-> (!mdc && $past(mdc)));
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int PRE_BITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] mdc_half,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  mdio_ctrl_t        ctrl_q;
  mdio_ctrl_t        wr_word;
  logic              accept;
  logic              start;
  logic              active;
  logic              rise_tick;
  logic              fall_tick;
  logic              done;
  logic [DATA_W-1:0] rd_data;
  logic              busy;

  assign wr_word   = mdio_ctrl_t'(reg_wdata);
  assign busy      = ctrl_q.go;
  assign accept    = reg_wr && !busy;
  assign start     = accept && wr_word.go && wr_word.en;
  assign reg_rdata = CTRL_W'(ctrl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (accept) begin
      ctrl_q    <= wr_word;
      ctrl_q.go <= wr_word.go && wr_word.en;
    end else if (done) begin
      ctrl_q.go <= 1'b0;
      if (ctrl_q.rd) ctrl_q.data <= rd_data;
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(active), .half(mdc_half),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_shifter #(.PRE_BITS(PRE_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_rd(wr_word.rd), .cmd_phy(wr_word.phy), .cmd_reg(wr_word.regn),
    .cmd_data(wr_word.data), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdc(mdc), .mdio_i(mdio_i), .active(active), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .done(done), .rd_data(rd_data)
  );

  // R7
  cmd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && !done) |=> (reg_rdata == $past(reg_rdata)));
  // R3
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  // R3
  end_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(mdc) && !mdc));
  // R1
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
endmodule

// File: tb/sim_mdio_cmd_master.sv
module sim_mdio_cmd_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mdc_half = 8'd1;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_drv = 1'b1;
  logic        cur_rd = 1'b0;
  logic [15:0] phy_val = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = !clk;

  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  mdio_cmd_master u0 (
    .clk(clk), .rst_n(rst_n), .mdc_half(mdc_half), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [63:0] exp_q[$];
  logic [63:0] oe_q[$];
  logic [63:0] cap = '0;
  logic [63:0] oecap = '0;
  logic        mdc_prev = 1'b0;
  int          rises = 0;

  // monitor: rising MDC edges are seen at the falling clock edge after them
  always @(negedge clk) begin
    if (mdc && !mdc_prev) begin
      cap   = {cap[62:0], mdio_o & mdio_oe | phy_drv & !mdio_oe};
      oecap = {oecap[62:0], mdio_oe};
      rises++;
      if (rises == 64) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R4: actual unexpected frame %h expected none", cap);
        end else begin
          chk("R4/R6 frame bits", cap, exp_q.pop_front());
          chk("R4/R6 output enable", oecap, oe_q.pop_front());
        end
        rises = 0;
      end
    end
    if (!mdc && mdc_prev) begin
      if (cur_rd && rises == 47) phy_drv = 1'b0;
      else if (cur_rd && rises >= 48 && rises <= 63) phy_drv = phy_val[63-rises];
      else phy_drv = 1'b1;
    end
    mdc_prev = mdc;
  end

  function automatic logic [31:0] mk(input logic rd, input logic [4:0] phy,
                                     input logic [4:0] rg, input logic [15:0] d);
    return {1'b1, 1'b1, 2'b00, rd, 1'b0, phy, rg, d};
  endfunction

  task automatic run_cmd(input logic [31:0] w, input int n, input logic [15:0] pd,
                         input bit intrude);
    int busy_n = 0;
    int hi_n   = 0;
    logic [31:0] fin;
    cur_rd   = w[27];
    phy_val  = pd;
    mdc_half = 8'(n);
    exp_q.push_back({32'hFFFF_FFFF, 2'b01, (w[27] ? 2'b10 : 2'b01), w[25:21],
                     w[20:16], 2'b10, (w[27] ? pd : w[15:0])});
    oe_q.push_back(w[27] ? ~64'h3FFFF : ~64'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
    while (reg_rdata[31] && busy_n < 100000) begin
      if (busy_n == 0) chk("R2 word held while busy", 64'(reg_rdata), 64'(w));
      if (mdc) hi_n++;
      busy_n++;
      if (intrude && busy_n == 10) begin
        reg_wr = 1'b1; reg_wdata = ~w;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R7 write while busy ignored", 64'(reg_rdata), 64'(w));
        if (mdc) hi_n++;
        busy_n++;
      end
      @(negedge clk);
    end
    chk("R2 busy cycles", 64'(busy_n), 64'(128 * (n + 1)));
    chk("R3 MDC high cycles", 64'(hi_n), 64'(64 * (n + 1)));
    fin = w[27] ? {1'b0, w[30:16], pd} : {1'b0, w[30:0]};
    chk(w[27] ? "R6 read result" : "R2 final word", 64'(reg_rdata), 64'(fin));
  endtask

  task automatic no_frame(input logic [31:0] w, input logic [31:0] exp, input string req);
    int bad = 0;
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
    chk(req, 64'(reg_rdata), 64'(exp));
    repeat (40) begin
      if (mdc || mdio_oe || rises != 0) bad++;
      @(negedge clk);
    end
    chk({req, " no MDC activity"}, 64'(bad), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 word after reset", 64'(reg_rdata), 64'd0);
    chk("R1 MDC after reset", 64'(mdc), 64'd0);
    chk("R1 OE after reset", 64'(mdio_oe), 64'd0);
    run_cmd(mk(1'b0, 5'h01, 5'h04, 16'hA5C3), 1, 16'h0, 1'b0);
    run_cmd(mk(1'b1, 5'h1F, 5'h00, 16'h1234), 2, 16'h8001, 1'b0);
    run_cmd(mk(1'b0, 5'h00, 5'h1F, 16'hFFFF), 0, 16'h0, 1'b1);
    run_cmd(mk(1'b1, 5'h0A, 5'h15, 16'h0000), 3, 16'h5A3C, 1'b1);
    no_frame(32'h8123_4567, 32'h0123_4567, "R8 go without enable");
    no_frame(32'h4000_BEEF, 32'h4000_BEEF, "R9 store without go");
    repeat (5) @(negedge clk);
    chk("R4 all frames seen", 64'(exp_q.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule